// File: doc/BRIEF.md
# DRAM Idle Power-Down Sequencer

This block sits next to a DRAM command scheduler and decides, in the gap between two transactions, whether the device should sleep. For each gap the scheduler hands over a request: when the last command sequence ended, its own earliest-start time, when the next transaction arrives, and when the next refresh is due. The block also reads a sleep-mode select, a device-family flag and a set of timing values. When the gap is long enough, it issues a sleep-entry command and then a sleep-exit command on a valid/ready command port, each with its issue time. After that it returns the earliest time at which the scheduler may send its next normal command.

Two sleep styles are supported. Precharge power-down wakes at the earlier of the next request and the next refresh deadline, and never stays down for more than one refresh interval. Self-refresh wakes exactly when the next request arrives. While self-refresh is in force, a status flag tells the scheduler to leave out its own periodic refresh commands. Low-power device families wait a plain exit time after wake-up. Standard families wait their DLL-relock exit time less the activate-to-column delay, because that delay is already counted by the scheduler. The caller keeps each DLL-relock time at or above the activate-to-column delay.

Top module: `dram_idle_pd_seq`

## Requirements
- R1: With `mode` at 0 (no sleep) or 3 (reserved), the block emits no command and returns `res_next` equal to `req_start`.
- R2: The idle start is max(`req_end`, `req_start`). The wake target is min(`req_arrive`, `req_refdl`) in power-down mode (`mode`=1) and `req_arrive` in self-refresh mode (`mode`=2).
- R3: Power-down entry is issued only when the wake target is strictly greater than idle start plus `t_cke`. It carries `cmd_kind`=0 and `cmd_time` equal to the idle start.
- R4: Power-down exit carries `cmd_kind`=1. Its `cmd_time` is the wake target, limited to no more than idle start plus `t_refi`.
- R5: After power-down, `res_next` is the exit time plus `t_xp` when `lp_family`=1, or plus (`t_xpdll` - `t_rcd`) when `lp_family`=0.
- R6: Self-refresh entry is issued only when `req_arrive` is strictly greater than idle start plus `t_ckesr`. Entry carries `cmd_kind`=2 at the idle start, and exit carries `cmd_kind`=3 at `req_arrive`, with no cap.
- R7: After self-refresh, `res_next` is the exit time plus `t_xs` when `lp_family`=1, or plus (`t_xsdll` - `t_rcd`) when `lp_family`=0.
- R8: When the entry condition fails in a sleep mode, no command is emitted and `res_next` equals `req_start`.
- R9: Entry is always sent before its exit, and exit follows on the cycle after the entry handshake. While `cmd_valid` is high and `cmd_ready` is low, `cmd_kind` and `cmd_time` hold steady.
- R10: `sr_active` rises on the cycle after a self-refresh entry handshake and stays high until the next request is accepted, which clears it.
- R11: `req_ready` is low from acceptance until the result is delivered. `res_valid` is a single-cycle pulse that comes after the last command handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Gap request present |
| req_ready | output | 1 | Block can accept a gap request |
| mode | input | 2 | 0 none, 1 power-down, 2 self-refresh, 3 reserved (none) |
| lp_family | input | 1 | 1 = low-power device family, 0 = standard family |
| req_end | input | TW | End time of the last command sequence |
| req_start | input | TW | Scheduler earliest-start time |
| req_arrive | input | TW | Arrival time of the next transaction |
| req_refdl | input | TW | Next refresh deadline |
| t_cke | input | TW | Minimum clock-enable pulse |
| t_ckesr | input | TW | Minimum self-refresh residency |
| t_refi | input | TW | Refresh interval |
| t_xp | input | TW | Power-down exit time, low-power family |
| t_xpdll | input | TW | Power-down exit time with DLL relock |
| t_xs | input | TW | Self-refresh exit time, low-power family |
| t_xsdll | input | TW | Self-refresh exit time with DLL relock |
| t_rcd | input | TW | Activate-to-column delay |
| cmd_valid | output | 1 | Sleep command present |
| cmd_ready | input | 1 | Command port accepts |
| cmd_kind | output | 2 | 0 PD enter, 1 PD exit, 2 SR enter, 3 SR exit |
| cmd_time | output | TW | Issue time of the command |
| res_valid | output | 1 | Result pulse |
| res_next | output | TW | Earliest next normal command time |
| sr_active | output | 1 | Self-refresh in force; suppress periodic refresh |

## Verification
The hardest situations to reach are the exact boundaries. One is an idle gap equal to the minimum residency, where no entry must happen. Another is a power-down stay equal to the refresh interval, where the exit must not be capped. A third is a refresh deadline earlier than the request, which moves the power-down wake-up while self-refresh ignores it. The stimulus table places `req_arrive` and `req_refdl` one unit on either side of these thresholds. It also includes a gap that is negative because the request arrives before the idle start. A directed case holds `cmd_ready` low during a self-refresh entry. It checks that the command stays steady and that `sr_active` does not rise before the handshake.

// File: rtl/dram_idle_pd_pkg.sv
package dram_idle_pd_pkg;

  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_PD   = 2'd1;
  localparam logic [1:0] MODE_SR   = 2'd2;

  typedef enum logic [1:0] {
    K_PD_IN  = 2'd0,
    K_PD_OUT = 2'd1,
    K_SR_IN  = 2'd2,
    K_SR_OUT = 2'd3
  } dpd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_EXIT  = 2'd2,
    ST_DONE  = 2'd3
  } dpd_state_e;

endpackage

// File: rtl/dpd_rst_sync.sv
module dpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dpd_plan.sv
// Combinational sleep decision for one idle gap.
module dpd_plan
  import dram_idle_pd_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic [1:0]    mode,
  input  logic          lp_family,
  input  logic [TW-1:0] req_end,
  input  logic [TW-1:0] req_start,
  input  logic [TW-1:0] req_arrive,
  input  logic [TW-1:0] req_refdl,
  input  logic [TW-1:0] t_cke,
  input  logic [TW-1:0] t_ckesr,
  input  logic [TW-1:0] t_refi,
  input  logic [TW-1:0] t_xp,
  input  logic [TW-1:0] t_xpdll,
  input  logic [TW-1:0] t_xs,
  input  logic [TW-1:0] t_xsdll,
  input  logic [TW-1:0] t_rcd,
  output logic          do_enter,
  output logic          sel_sr,
  output logic [TW-1:0] t_ent,
  output logic [TW-1:0] t_exit,
  output logic [TW-1:0] t_next
);
  localparam int EW = TW + 1;

  logic          is_pd, is_sr;
  logic [TW-1:0] idle_start, wake, min_gap, stay, wake_wait, dll_wait;
  logic [EW-1:0] threshold;

  always_comb begin
    is_pd      = (mode == MODE_PD);
    is_sr      = (mode == MODE_SR);
    idle_start = (req_end > req_start) ? req_end : req_start;
    wake       = (is_pd && (req_refdl < req_arrive)) ? req_refdl : req_arrive;
    min_gap    = is_pd ? t_cke : t_ckesr;
    threshold  = {1'b0, idle_start} + {1'b0, min_gap};
    do_enter   = (is_pd || is_sr) && ({1'b0, wake} > threshold);
    stay       = wake - idle_start;
    t_exit     = (is_pd && (stay > t_refi)) ? (idle_start + t_refi) : wake;
    dll_wait   = (is_pd ? t_xpdll : t_xsdll) - t_rcd;
    wake_wait  = lp_family ? (is_pd ? t_xp : t_xs) : dll_wait;
    t_next     = do_enter ? (t_exit + wake_wait) : req_start;
    t_ent      = idle_start;
    sel_sr     = is_sr;
  end
endmodule

// File: rtl/dpd_seq.sv
// Command sequencing: accept, enter, exit, report.
module dpd_seq
  import dram_idle_pd_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          p_enter,
  input  logic          p_sr,
  input  logic [TW-1:0] p_ent,
  input  logic [TW-1:0] p_exit,
  input  logic [TW-1:0] p_next,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [TW-1:0] cmd_time,
  output logic          res_valid,
  output logic [TW-1:0] res_next,
  output logic          accept,
  output logic          sr_entered
);
  dpd_state_e    state_q, state_d;
  logic          sr_q;
  logic [TW-1:0] ent_q, exit_q, next_q;
  logic          load_en;

  assign accept  = req_valid && req_ready;
  assign load_en = accept;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept)    state_d = p_enter ? ST_ENTER : ST_DONE;
      ST_ENTER: if (cmd_ready) state_d = ST_EXIT;
      ST_EXIT:  if (cmd_ready) state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= 1'b0;
      ent_q  <= '0;
      exit_q <= '0;
      next_q <= '0;
    end else if (load_en) begin
      sr_q   <= p_sr;
      ent_q  <= p_ent;
      exit_q <= p_exit;
      next_q <= p_next;
    end
  end

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    cmd_valid  = (state_q == ST_ENTER) || (state_q == ST_EXIT);
    cmd_kind   = {sr_q, (state_q == ST_EXIT)};
    cmd_time   = (state_q == ST_EXIT) ? exit_q : ent_q;
    res_valid  = (state_q == ST_DONE);
    res_next   = next_q;
    sr_entered = (state_q == ST_ENTER) && cmd_ready && sr_q;
  end
endmodule

// File: rtl/dpd_srflag.sv
module dpd_srflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (set_en)      flag_d = 1'b1;
    else if (clr_en) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/dram_idle_pd_seq.sv
module dram_idle_pd_seq #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    mode,
  input  logic          lp_family,
  input  logic [TW-1:0] req_end,
  input  logic [TW-1:0] req_start,
  input  logic [TW-1:0] req_arrive,
  input  logic [TW-1:0] req_refdl,
  input  logic [TW-1:0] t_cke,
  input  logic [TW-1:0] t_ckesr,
  input  logic [TW-1:0] t_refi,
  input  logic [TW-1:0] t_xp,
  input  logic [TW-1:0] t_xpdll,
  input  logic [TW-1:0] t_xs,
  input  logic [TW-1:0] t_xsdll,
  input  logic [TW-1:0] t_rcd,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [TW-1:0] cmd_time,
  output logic          res_valid,
  output logic [TW-1:0] res_next,
  output logic          sr_active
);
  logic          rst_i_n;
  logic          p_enter, p_sr, accept, sr_entered;
  logic [TW-1:0] p_ent, p_exit, p_next;

  dpd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  dpd_plan #(.TW(TW)) u_plan (
    .mode(mode), .lp_family(lp_family),
    .req_end(req_end), .req_start(req_start),
    .req_arrive(req_arrive), .req_refdl(req_refdl),
    .t_cke(t_cke), .t_ckesr(t_ckesr), .t_refi(t_refi),
    .t_xp(t_xp), .t_xpdll(t_xpdll), .t_xs(t_xs), .t_xsdll(t_xsdll),
    .t_rcd(t_rcd),
    .do_enter(p_enter), .sel_sr(p_sr),
    .t_ent(p_ent), .t_exit(p_exit), .t_next(p_next)
  );

  dpd_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .p_enter(p_enter), .p_sr(p_sr),
    .p_ent(p_ent), .p_exit(p_exit), .p_next(p_next),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_time(cmd_time),
    .res_valid(res_valid), .res_next(res_next),
    .accept(accept), .sr_entered(sr_entered)
  );

  dpd_srflag u_srflag (
    .clk(clk), .rst_n(rst_i_n),
    .set_en(sr_entered), .clr_en(accept), .flag(sr_active)
  );
endmodule

// File: rtl/dram_idle_pd_seq_chk.sv
module dram_idle_pd_seq_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    mode,
  input logic [TW-1:0] t_refi,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_kind,
  input logic [TW-1:0] cmd_time,
  input logic          res_valid,
  input logic          sr_active
);
  logic          none_q;
  logic [TW-1:0] ent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      none_q <= 1'b1;
      ent_q  <= '0;
    end else begin
      if (req_valid && req_ready) none_q <= !(mode == 2'd1 || mode == 2'd2);
      if (cmd_valid && cmd_ready && !cmd_kind[0]) ent_q <= cmd_time;
    end
  end

  assert_no_cmd_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    none_q |-> !cmd_valid);

  assert_pd_exit_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd1) |->
      ({1'b0, cmd_time} <= {1'b0, ent_q} + {1'b0, t_refi}) && (cmd_time >= ent_q));

  assert_exit_follows_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_kind[0]) |=> (cmd_valid && cmd_kind[0]));

  assert_cmd_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_kind) && $stable(cmd_time)));

  assert_sr_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'd2) |=> sr_active);

  assert_sr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !sr_active);

  assert_busy_no_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || res_valid) |-> !req_ready);

  assert_res_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

bind dram_idle_pd_seq dram_idle_pd_seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mode(mode), .t_refi(t_refi), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_kind(cmd_kind), .cmd_time(cmd_time), .res_valid(res_valid),
  .sr_active(sr_active)
);

// File: tb/dram_idle_pd_seq_test.sv
`timescale 1ns/1ps
module dram_idle_pd_seq_test;
  localparam int TW = 32;

  typedef struct packed {
    logic [1:0]    mode;
    logic          lp;
    logic [TW-1:0] t_end;
    logic [TW-1:0] t_start;
    logic [TW-1:0] t_arr;
    logic [TW-1:0] t_rdl;
    logic          x_enter;
    logic [TW-1:0] x_ent;
    logic [TW-1:0] x_exit;
    logic [TW-1:0] x_next;
    logic          x_sr;
  } vec_t;

  localparam int NV = 12;
  // timings: cke 3, ckesr 5, refi 100, xp 2, xpdll 20, xs 10, xsdll 40, rcd 6
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 32'd50,  32'd40, 32'd200,  32'd1000, 1'b0, 32'd0,   32'd0,    32'd40,   1'b0}, // R1 off
    '{2'd1, 1'b1, 32'd50,  32'd40, 32'd80,   32'd1000, 1'b1, 32'd50,  32'd80,   32'd82,   1'b0}, // R3 R5
    '{2'd1, 1'b0, 32'd10,  32'd20, 32'd500,  32'd1000, 1'b1, 32'd20,  32'd120,  32'd134,  1'b0}, // R4 cap, R5 ddr
    '{2'd1, 1'b1, 32'd0,   32'd0,  32'd500,  32'd60,   1'b1, 32'd0,   32'd60,   32'd62,   1'b0}, // R2 refresh wake
    '{2'd1, 1'b1, 32'd50,  32'd40, 32'd53,   32'd1000, 1'b0, 32'd0,   32'd0,    32'd40,   1'b0}, // R8 gap == cke
    '{2'd1, 1'b1, 32'd50,  32'd40, 32'd54,   32'd1000, 1'b1, 32'd50,  32'd54,   32'd56,   1'b0}, // R3 gap cke+1
    '{2'd2, 1'b1, 32'd100, 32'd0,  32'd106,  32'd1000, 1'b1, 32'd100, 32'd106,  32'd116,  1'b1}, // R6 R7
    '{2'd2, 1'b1, 32'd100, 32'd0,  32'd105,  32'd1000, 1'b0, 32'd0,   32'd0,    32'd0,    1'b0}, // R8 gap == ckesr
    '{2'd2, 1'b0, 32'd0,   32'd30, 32'd1000, 32'd50,   1'b1, 32'd30,  32'd1000, 32'd1034, 1'b1}, // R6 no cap, R7 ddr
    '{2'd1, 1'b1, 32'd100, 32'd0,  32'd20,   32'd1000, 1'b0, 32'd0,   32'd0,    32'd0,    1'b0}, // R8 arrive early
    '{2'd3, 1'b1, 32'd50,  32'd40, 32'd200,  32'd1000, 1'b0, 32'd0,   32'd0,    32'd40,   1'b0}, // R1 reserved
    '{2'd1, 1'b1, 32'd0,   32'd0,  32'd100,  32'd1000, 1'b1, 32'd0,   32'd100,  32'd102,  1'b0}  // R4 stay == refi
  };

  logic          clk, rst_n;
  logic          req_valid, req_ready, lp_family, cmd_valid, cmd_ready, res_valid, sr_active;
  logic [1:0]    mode, cmd_kind;
  logic [TW-1:0] req_end, req_start, req_arrive, req_refdl, cmd_time, res_next;
  logic [TW-1:0] t_cke, t_ckesr, t_refi, t_xp, t_xpdll, t_xs, t_xsdll, t_rcd;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  dram_idle_pd_seq #(.TW(TW)) uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic send(input vec_t v);
    while (!req_ready) @(negedge clk);
    mode = v.mode; lp_family = v.lp;
    req_end = v.t_end; req_start = v.t_start; req_arrive = v.t_arr; req_refdl = v.t_rdl;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic collect(input vec_t v, input int idx);
    int nc = 0;
    logic [1:0]    k [2];
    logic [TW-1:0] tm [2];
    logic [TW-1:0] nx = '0;
    bit got = 0;
    for (int c = 0; c < 20 && !got; c++) begin
      if (cmd_valid && cmd_ready) begin
        if (nc < 2) begin k[nc] = cmd_kind; tm[nc] = cmd_time; end
        nc++;
      end
      if (res_valid) begin nx = res_next; got = 1; end
      else @(negedge clk);
    end
    check("R11", $sformatf("v%0d result pulse", idx), TW'(got), TW'(1));
    check(v.x_enter ? "R9" : "R8", $sformatf("v%0d cmd count", idx), TW'(nc), v.x_enter ? TW'(2) : TW'(0));
    if (v.x_enter && nc == 2) begin
      check(v.mode == 2'd2 ? "R6" : "R3", $sformatf("v%0d entry kind", idx), TW'(k[0]), v.mode == 2'd2 ? TW'(2) : TW'(0));
      check(v.mode == 2'd2 ? "R6" : "R3", $sformatf("v%0d entry time", idx), tm[0], v.x_ent);
      check(v.mode == 2'd2 ? "R6" : "R4", $sformatf("v%0d exit kind", idx), TW'(k[1]), v.mode == 2'd2 ? TW'(3) : TW'(1));
      check(v.mode == 2'd2 ? "R6" : "R4", $sformatf("v%0d exit time", idx), tm[1], v.x_exit);
    end
    check(v.mode == 2'd2 ? "R7" : "R5", $sformatf("v%0d next time", idx), res_next, v.x_next);
    if (got) check("R2", $sformatf("v%0d next latched", idx), nx, v.x_next);
    check("R10", $sformatf("v%0d sr flag", idx), TW'(sr_active), TW'(v.x_sr));
    @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    vec_t d;
    rst_n = 1'b0; req_valid = 1'b0; cmd_ready = 1'b1; mode = 2'd0; lp_family = 1'b1;
    req_end = '0; req_start = '0; req_arrive = '0; req_refdl = '0;
    t_cke = 3; t_ckesr = 5; t_refi = 100; t_xp = 2; t_xpdll = 20;
    t_xs = 10; t_xsdll = 40; t_rcd = 6;
    repeat (3) @(negedge clk);
    check("R11", "reset cmd_valid", TW'(cmd_valid), 0);
    check("R11", "reset res_valid", TW'(res_valid), 0);
    check("R10", "reset sr_active", TW'(sr_active), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "idle req_ready", TW'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      send(VECS[i]);
      collect(VECS[i], i);
    end

    // R9 R10: self-refresh entry held under backpressure
    d = '{2'd2, 1'b1, 32'd200, 32'd0, 32'd300, 32'd1000, 1'b1, 32'd200, 32'd300, 32'd310, 1'b1};
    cmd_ready = 1'b0;
    send(d);
    for (int c = 0; c < 3; c++) begin
      check("R9", "held valid", TW'(cmd_valid), 1);
      check("R9", "held kind", TW'(cmd_kind), 2);
      check("R9", "held time", cmd_time, 200);
      check("R10", "flag before handshake", TW'(sr_active), 0);
      check("R11", "busy not ready", TW'(req_ready), 0);
      @(negedge clk);
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    check("R9", "exit after entry kind", TW'(cmd_kind), 3);
    check("R9", "exit after entry time", cmd_time, 300);
    check("R10", "flag after entry", TW'(sr_active), 1);
    @(negedge clk);
    check("R11", "result pulse", TW'(res_valid), 1);
    check("R7", "result next", res_next, 310);
    @(negedge clk);
    check("R11", "pulse single", TW'(res_valid), 0);
    check("R10", "flag persists", TW'(sr_active), 1);
    // next accepted request clears the flag
    send(VECS[0]);
    check("R10", "flag cleared on accept", TW'(sr_active), 0);
    collect(VECS[0], 99);

    finish_run();
  end
endmodule